// File: doc/BRIEF.md
# Supply Sequencing and Reset Controller

This block turns regulators on and off in a fixed order and drives two active-low reset lines. Its inputs are comparator flags that are already synchronized to the clock. The flags report whether the ignition key is present, whether the battery is good, and whether each of several rails is good. One more flag reports that the peripheral-minus-core voltage difference is over its limit.

The controller keeps a power level from 0 to 4. Each level turns on one more regulator, in this order: boost, saturation, peripheral, core. A level is left for the next one only when the rail enabled at that level reports good. When the key or the battery goes away, the enables are removed in the reverse order, one per clock. A difference fault with the peripheral rail enabled drops every enable at once.

The two reset lines are built as identical, independent channels. Each channel pulls its line low at once when the internal supply, the peripheral rail or the core rail is bad. A boost-rail dip pulls the line low only after a qualifying time has passed, so short dips on the boost rail are ignored.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While rst_ni is low, all four enables are 0 and both reset outputs are 0.
- R2: From level 0 (all enables off), the next edge turns on boost_en_o only if key_i=1, batt_ok_i=1 and diff_over_i=0 are all sampled at that edge.
- R3: With only boost enabled, sampling boost_ok_i=1 turns on sat_en_o at that edge.
- R4: With boost and saturation enabled, sampling sat_ok_i=1 turns on peri_en_o at that edge.
- R5: With peripheral enabled, sampling peri_ok_i=1 turns on core_en_o at that edge.
- R6: When peri_en_o=1 and diff_over_i=1 are sampled at an edge, all four enables are 0 after that edge. The block then stays at level 0 as long as diff_over_i stays 1.
- R7: When key_i=0 or batt_ok_i=0 is sampled, the most recently enabled regulator is turned off at that edge. The order of removal is core, then peripheral, then saturation, then boost, one per edge.
- R8: A dip on boost_ok_i that covers fewer than FILT_CYC consecutive samples never changes either reset output. FILT_CYC = CLK_KHZ*FILT_US/1000, which is 4000 at the default values.
- R9: After FILT_CYC consecutive samples of boost_ok_i=0, both resets go low at the following edge. They rise again on the second edge after boost_ok_i is first sampled as 1, provided the other flags are good.
- R10: Sampling vint_ok_i=0, peri_ok_i=0 or core_ok_i=0 at an edge drives both resets low after that edge.
- R11: The two reset outputs are always equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| key_i | input | 1 | Ignition key present |
| batt_ok_i | input | 1 | Battery good |
| boost_ok_i | input | 1 | Boost rail good |
| sat_ok_i | input | 1 | Saturation rail good |
| peri_ok_i | input | 1 | Peripheral rail good |
| core_ok_i | input | 1 | Core rail good |
| diff_over_i | input | 1 | Peripheral-minus-core difference over its limit |
| vint_ok_i | input | 1 | Internal supply good |
| boost_en_o | output | 1 | Boost regulator enable |
| sat_en_o | output | 1 | Saturation regulator enable |
| peri_en_o | output | 1 | Peripheral regulator enable |
| core_en_o | output | 1 | Core regulator enable |
| rst_main_no | output | 1 | Main reset, active low |
| rst_red_no | output | 1 | Redundant reset, active low |

## Verification
Every enable change and every reset drop caused by the internal-supply, peripheral or core flag appears one edge after the input is sampled. A long boost dip shows up on the resets one edge after its FILT_CYC-th sample. The release after that dip comes two edges after the boost flag recovers. The bench drives its inputs on falling edges and updates a cycle model at each rising edge. It compares the outputs at the next falling edge, so every check lands exactly in the cycle where the result is due. Directed dips of FILT_CYC-1 and FILT_CYC samples mark the filter boundary precisely.

// File: rtl/pwr_seq_pkg.sv
`timescale 1ns/1ps
package pwr_seq_pkg;
  localparam int NUM_RAILS = 4;
  localparam int NUM_RST   = 2;

  typedef enum logic [2:0] {
    LVL_OFF   = 3'd0,
    LVL_BOOST = 3'd1,
    LVL_SAT   = 3'd2,
    LVL_PERI  = 3'd3,
    LVL_CORE  = 3'd4
  } lvl_e;
endpackage

// File: rtl/pwr_seq_fsm.sv
`timescale 1ns/1ps
module pwr_seq_fsm
  import pwr_seq_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 go_i,
  input  logic                 diff_i,
  input  logic                 boost_ok_i,
  input  logic                 sat_ok_i,
  input  logic                 peri_ok_i,
  output logic [NUM_RAILS-1:0] en_o
);
  lvl_e lvl_q, lvl_d;

  always_comb begin
    lvl_d = lvl_q;
    if (lvl_q >= LVL_PERI && diff_i) begin
      lvl_d = LVL_OFF;
    end else if (lvl_q == LVL_OFF) begin
      if (go_i && !diff_i) lvl_d = LVL_BOOST;
    end else if (!go_i) begin
      // reverse order: drop most recent rail
      unique case (lvl_q)
        LVL_CORE:  lvl_d = LVL_PERI;
        LVL_PERI:  lvl_d = LVL_SAT;
        LVL_SAT:   lvl_d = LVL_BOOST;
        default:   lvl_d = LVL_OFF;
      endcase
    end else begin
      unique case (lvl_q)
        LVL_BOOST: if (boost_ok_i) lvl_d = LVL_SAT;
        LVL_SAT:   if (sat_ok_i)   lvl_d = LVL_PERI;
        LVL_PERI:  if (peri_ok_i)  lvl_d = LVL_CORE;
        default:   lvl_d = lvl_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= LVL_OFF;
    else         lvl_q <= lvl_d;
  end

  for (genvar k = 0; k < NUM_RAILS; k++) begin : g_en
    assign en_o[k] = (lvl_q > lvl_e'(k));
  end
endmodule

// File: rtl/rst_glitch_filt.sv
`timescale 1ns/1ps
module rst_glitch_filt #(
  parameter int LIM = 4000,
  localparam int CW = $clog2(LIM + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dip_ok_i,
  input  logic hard_ok_i,
  output logic rst_no
);
  logic [CW-1:0] cnt_q;
  logic          trip;
  logic          rst_q;

  assign trip = (cnt_q == CW'(LIM));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rst_q <= 1'b0;
    end else begin
      rst_q <= hard_ok_i && !trip;
      if (dip_ok_i)   cnt_q <= '0;
      else if (!trip) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign rst_no = rst_q;
endmodule

// File: rtl/pwr_seq_ctrl.sv
`timescale 1ns/1ps
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int CLK_KHZ = 200000,
  parameter int FILT_US = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic key_i,
  input  logic batt_ok_i,
  input  logic boost_ok_i,
  input  logic sat_ok_i,
  input  logic peri_ok_i,
  input  logic core_ok_i,
  input  logic diff_over_i,
  input  logic vint_ok_i,
  output logic boost_en_o,
  output logic sat_en_o,
  output logic peri_en_o,
  output logic core_en_o,
  output logic rst_main_no,
  output logic rst_red_no
);
  localparam int FILT_CYC = CLK_KHZ * FILT_US / 1000;

  logic [NUM_RAILS-1:0] en;
  logic [NUM_RST-1:0]   rst_n;
  logic                 hard_ok;

  pwr_seq_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .go_i       (key_i && batt_ok_i),
    .diff_i     (diff_over_i),
    .boost_ok_i (boost_ok_i),
    .sat_ok_i   (sat_ok_i),
    .peri_ok_i  (peri_ok_i),
    .en_o       (en)
  );

  assign hard_ok = vint_ok_i && peri_ok_i && core_ok_i;

  // independent channels, one per reset line
  for (genvar i = 0; i < NUM_RST; i++) begin : g_rst
    rst_glitch_filt #(.LIM(FILT_CYC)) u_filt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .dip_ok_i  (boost_ok_i),
      .hard_ok_i (hard_ok),
      .rst_no    (rst_n[i])
    );
  end

  assign boost_en_o  = en[0];
  assign sat_en_o    = en[1];
  assign peri_en_o   = en[2];
  assign core_en_o   = en[3];
  assign rst_main_no = rst_n[0];
  assign rst_red_no  = rst_n[1];
endmodule

// File: rtl/pwr_seq_ctrl_chk.sv
`timescale 1ns/1ps
module pwr_seq_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic key_i,
  input logic batt_ok_i,
  input logic boost_ok_i,
  input logic sat_ok_i,
  input logic peri_ok_i,
  input logic core_ok_i,
  input logic diff_over_i,
  input logic vint_ok_i,
  input logic boost_en_o,
  input logic sat_en_o,
  input logic peri_en_o,
  input logic core_en_o,
  input logic rst_main_no,
  input logic rst_red_no
);
  p_boost_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(boost_en_o) |-> $past(key_i && batt_ok_i && !diff_over_i));

  p_sat_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sat_en_o) |-> $past(boost_ok_i));

  p_peri_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(peri_en_o) |-> $past(sat_ok_i));

  p_core_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(core_en_o) |-> $past(peri_ok_i));

  p_diff_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (peri_en_o && diff_over_i) |=> (!boost_en_o && !sat_en_o && !peri_en_o && !core_en_o));

  p_step_down_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_en_o && !(key_i && batt_ok_i) && !diff_over_i) |=> (!core_en_o && peri_en_o));

  p_hard_bad_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(vint_ok_i && peri_ok_i && core_ok_i) |=> (!rst_main_no && !rst_red_no));

  p_twin_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_main_no == rst_red_no);
endmodule

bind pwr_seq_ctrl pwr_seq_ctrl_chk u_chk (.*);

// File: tb/pwr_seq_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_seq_ctrl_tb;
  localparam int LIM = 4000;  // 20 us at 200 MHz

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, key, batt, boost, sat, peri, core, diff, vint;
  logic boost_en, sat_en, peri_en, core_en, rst_main, rst_red;

  pwr_seq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .key_i(key), .batt_ok_i(batt),
    .boost_ok_i(boost), .sat_ok_i(sat), .peri_ok_i(peri), .core_ok_i(core),
    .diff_over_i(diff), .vint_ok_i(vint),
    .boost_en_o(boost_en), .sat_en_o(sat_en), .peri_en_o(peri_en),
    .core_en_o(core_en), .rst_main_no(rst_main), .rst_red_no(rst_red)
  );

  int checks = 0;
  int errors = 0;
  int m_lvl  = 0;
  int m_cnt  = 0;
  bit m_rst  = 0;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit go;
    go = key && batt;
    m_rst = vint && peri && core && (m_cnt != LIM);
    if (boost) m_cnt = 0;
    else if (m_cnt != LIM) m_cnt++;
    if (m_lvl >= 3 && diff) m_lvl = 0;
    else if (m_lvl == 0) begin
      if (go && !diff) m_lvl = 1;
    end else if (!go) m_lvl--;
    else if (m_lvl == 1 && boost) m_lvl = 2;
    else if (m_lvl == 2 && sat) m_lvl = 3;
    else if (m_lvl == 3 && peri) m_lvl = 4;
  endtask

  function automatic int en_word();
    return {28'd0, core_en, peri_en, sat_en, boost_en};
  endfunction

  function automatic int lvl_word(int l);
    return (1 << l) - 1;
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    model_step();
    check("R2/R3/R4/R5/R6/R7 enables", en_word(), lvl_word(m_lvl));
    check("R8/R9/R10 reset", int'(rst_main), int'(m_rst));
    check("R11 twin reset", int'(rst_red), int'(rst_main));
  endtask

  task automatic all_good();
    key = 1; batt = 1; boost = 1; sat = 1; peri = 1; core = 1; diff = 0; vint = 1;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 act=hung exp=done");
    finish_run();
  end

  initial begin
    rst_n = 0; key = 0; batt = 0; boost = 0; sat = 0; peri = 0; core = 0; diff = 0; vint = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    all_good();
    @(negedge clk);
    // R1 reset state
    check("R1 enables in reset", en_word(), 0);
    check("R1 main reset in reset", int'(rst_main), 0);
    check("R1 redundant reset in reset", int'(rst_red), 0);
    rst_n = 1;

    // R2: key without battery keeps boost off
    batt = 0; boost = 0; sat = 0; peri = 0;
    repeat (3) step();
    check("R2 no battery", int'(boost_en), 0);
    diff = 1; batt = 1;
    step();
    check("R2 diff blocks start", int'(boost_en), 0);
    diff = 0;
    step();
    check("R2 boost on", en_word(), 1);
    step();
    check("R3 waits for boost good", int'(sat_en), 0);
    boost = 1; step();
    check("R3 sat on", en_word(), 3);
    sat = 1; step();
    check("R4 peri on", en_word(), 7);
    peri = 1; step();
    check("R5 core on", en_word(), 15);

    // R7 reverse order
    key = 0;
    step(); check("R7 core off first", en_word(), 7);
    step(); check("R7 peri off", en_word(), 3);
    step(); check("R7 sat off", en_word(), 1);
    step(); check("R7 boost off", en_word(), 0);

    // R6 difference fault
    all_good();
    repeat (4) step();
    check("R6 precondition full", en_word(), 15);
    diff = 1; step();
    check("R6 all off", en_word(), 0);
    repeat (3) step();
    check("R6 held idle", en_word(), 0);
    diff = 0; step();
    check("R6 restart", en_word(), 1);
    repeat (3) step();

    // R10 hard flags
    vint = 0; step();
    check("R10 vint bad", int'(rst_main), 0);
    vint = 1; step();
    check("R10 recovered", int'(rst_main), 1);
    core = 0; step();
    check("R10 core bad", int'(rst_red), 0);
    core = 1; step();

    // R8 short dip
    boost = 0;
    repeat (LIM - 1) step();
    boost = 1; step(); step();
    check("R8 short dip ignored", int'(rst_main), 1);
    // R9 long dip
    boost = 0;
    repeat (LIM) step();
    check("R9 still high at LIM", int'(rst_main), 1);
    boost = 1; step();
    check("R9 low after LIM samples", int'(rst_main), 0);
    check("R11 twin low", int'(rst_red), 0);
    step();
    check("R9 release", int'(rst_main), 1);

    // random mix
    for (int i = 0; i < 40000; i++) begin
      if ($urandom_range(1999) == 0) key = ~key;
      if ($urandom_range(2999) == 0) batt = ~batt;
      if (boost) begin if ($urandom_range(499) == 0) boost = 0; end
      else if ($urandom_range(29) == 0) boost = 1;
      if ($urandom_range(299) == 0) sat = ~sat;
      if ($urandom_range(299) == 0) peri = ~peri;
      if ($urandom_range(299) == 0) core = ~core;
      if (diff) begin if ($urandom_range(19) == 0) diff = 0; end
      else if ($urandom_range(799) == 0) diff = 1;
      if (vint) begin if ($urandom_range(999) == 0) vint = 0; end
      else if ($urandom_range(4) == 0) vint = 1;
      if (!key && $urandom_range(3) == 0) key = 1;
      step();
    end
    finish_run();
  end
endmodule